// File: doc/BRIEF.md
# Banked GPIO Controller with Event Sensing

This block is a memory-mapped general-purpose I/O controller. It serves 96 pins, split into three banks of 32. Pin n belongs to bank n/32 and sits at bit n%32 of that bank's registers. For each pin, software sets the direction, an input inversion and an output latch. The latch can be written whole, or bits can be raised or lowered on their own through separate set and clear registers. Pad inputs pass through a two-flop synchroniser before anything reads them.

Every pin can raise events on a rising edge, a falling edge, a high level or a low level, and each of the four has its own enable. Events are held in a per-bank pending register. Software acknowledges a pending bit by writing a one to it. A companion register marks which pending bits came from edges. One interrupt line covers all three banks.

Access is through a 32-bit request/response port. The request side uses valid/ready, and ready is held high permanently, so a request is taken in every cycle that `req_valid` is high. A read returns `rsp_valid` together with its data exactly one cycle later. The response has no ready signal, so the requester must take it in the cycle it appears. Writes return nothing.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: Register address = group*16 + 4*bank, with address bits [1:0] zero. Groups are: 0 direction, 1 polarity, 2 data, 3 set, 4 clear, 5 rise enable, 6 fall enable, 7 high enable, 8 low enable, 9 pending, 10 edge flag. Bank slot 3, groups 11 to 15 and misaligned addresses are ignored on write and read as 0.
- R2: `req_ready` is always 1. A read accepted at a clock edge gives `rsp_valid`=1 with its data after that edge. After a write or an idle cycle, `rsp_valid` is 0.
- R3: `pad_oe` carries the direction bits (1 = output) and `pad_out` carries the output latch. Reset clears every register, so all pins start as inputs with a zero latch and no interrupt.
- R4: A read of the data group returns the latch bit for output pins and the synchronised, polarity-adjusted pad for input pins. A pad change shows up in the second read started after it, not the first.
- R5: A write to the set group raises only the latch bits written as 1. All other bits keep their value.
- R6: A write to the clear group lowers only the latch bits written as 1. All other bits keep their value.
- R7: A polarity bit of 1 inverts that pad before data readback and before event detection.
- R8: With rise enabled, a 0→1 change of the sensed value sets the pending bit. With fall enabled, a 1→0 change sets it. With both enabled, both edges set it.
- R9: An enabled high or low level sets the pending bit in every cycle it persists, so acknowledging it has no effect while the level remains.
- R10: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R11: The edge-flag bit is 1 only when its pending bit was set by an edge. It is cleared together with that pending bit, and writes to it are ignored.
- R12: `irq` is 1 whenever any pending bit in any bank is set.
- R13: An event whose enable is 0 sets no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| pad_in | input | 96 | Raw pad inputs |
| pad_out | output | 96 | Output latch to pads |
| pad_oe | output | 96 | Output enables to pads |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: three banks of 32 pins. At this size the unused fourth bank slot in every register group is still present, so the ignored-address rule can be exercised. The top bank's bits are also reachable, which lets the bench show that pending bits from different banks all drive the one shared interrupt. Events are placed in bank 0, bank 1 and bank 2, so the interleaved address decode is tested in every group that is used.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SLOT_W = 2;
  localparam int unsigned GRP_W  = 4;

  typedef enum logic [GRP_W-1:0] {
    GRP_DIR  = 4'h0,
    GRP_POL  = 4'h1,
    GRP_DATA = 4'h2,
    GRP_SET  = 4'h3,
    GRP_CLR  = 4'h4,
    GRP_RISE = 4'h5,
    GRP_FALL = 4'h6,
    GRP_HIGH = 4'h7,
    GRP_LOW  = 4'h8,
    GRP_STAT = 4'h9,
    GRP_EDGE = 4'hA
  } grp_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 96
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
    end
  end

  assign dout = stab_q;
endmodule

// File: rtl/gpio_regif.sv
module gpio_regif
  import gpio_pkg::*;
#(
  parameter int unsigned NB = 3,
  parameter int unsigned W  = DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [NB-1:0][W-1:0]   bank_rd,
  output logic [NB-1:0]          bank_wr,
  output logic [GRP_W-1:0]       grp,
  output logic                   rsp_valid,
  output logic [W-1:0]           rsp_rdata
);
  logic [SLOT_W-1:0] slot;
  logic              hit;
  logic [W-1:0]      rd_sel;

  assign grp  = req_addr[ADDR_W-1:ADDR_W-GRP_W];
  assign slot = req_addr[SLOT_W+1:2];
  assign hit  = (grp <= GRP_EDGE) && (req_addr[1:0] == 2'b00) && (int'(slot) < NB);

  for (genvar b = 0; b < NB; b++) begin : g_wr
    assign bank_wr[b] = req_valid && req_write && hit && (int'(slot) == b);
  end

  always_comb begin
    rd_sel = '0;
    for (int b = 0; b < NB; b++) begin
      if (hit && int'(slot) == b) rd_sel = bank_rd[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_sel : '0;
    end
  end

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);                                  // R2
  AST_NO_RSP_UNASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);                                // R2
  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bank_wr == '0));                                                 // R1
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [GRP_W-1:0] grp,
  input  logic [W-1:0]     wdata,
  input  logic [W-1:0]     pin_sync,
  output logic [W-1:0]     rd_data,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_oe,
  output logic             pend_any
);
  logic [W-1:0] dir_q, pol_q, dout_q;
  logic [W-1:0] ren_q, fen_q, hen_q, len_q;
  logic [W-1:0] stat_q, edg_q, prev_q;
  logic [W-1:0] sensed, edge_ev, lvl_ev, ev, ack;

  assign sensed  = pin_sync ^ pol_q;
  assign edge_ev = (sensed & ~prev_q & ren_q) | (~sensed & prev_q & fen_q);
  assign lvl_ev  = (sensed & hen_q) | (~sensed & len_q);
  assign ev      = edge_ev | lvl_ev;
  assign ack     = (wr_en && grp == GRP_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      pol_q  <= '0;
      dout_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      hen_q  <= '0;
      len_q  <= '0;
    end else if (wr_en) begin
      case (grp)
        GRP_DIR:  dir_q  <= wdata;
        GRP_POL:  pol_q  <= wdata;
        GRP_DATA: dout_q <= wdata;
        GRP_SET:  dout_q <= dout_q | wdata;
        GRP_CLR:  dout_q <= dout_q & ~wdata;
        GRP_RISE: ren_q  <= wdata;
        GRP_FALL: fen_q  <= wdata;
        GRP_HIGH: hen_q  <= wdata;
        GRP_LOW:  len_q  <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
      edg_q  <= '0;
    end else begin
      prev_q <= sensed;
      stat_q <= (stat_q & ~ack) | ev;
      edg_q  <= (edg_q & ~ack) | edge_ev;
    end
  end

  always_comb begin
    case (grp)
      GRP_DIR:  rd_data = dir_q;
      GRP_POL:  rd_data = pol_q;
      GRP_DATA: rd_data = (dir_q & dout_q) | (~dir_q & sensed);
      GRP_SET:  rd_data = dout_q;
      GRP_CLR:  rd_data = dout_q;
      GRP_RISE: rd_data = ren_q;
      GRP_FALL: rd_data = fen_q;
      GRP_HIGH: rd_data = hen_q;
      GRP_LOW:  rd_data = len_q;
      GRP_STAT: rd_data = stat_q;
      GRP_EDGE: rd_data = edg_q;
      default:  rd_data = '0;
    endcase
  end

  assign pad_out  = dout_q;
  assign pad_oe   = dir_q;
  assign pend_any = |stat_q;

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && grp == GRP_SET) |=> (((dout_q & $past(wdata)) == $past(wdata)) &&
      ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata)))));        // R5
  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && grp == GRP_CLR) |=> (((dout_q & $past(wdata)) == '0) &&
      ((dout_q & ~$past(wdata)) == ($past(dout_q) & ~$past(wdata)))));        // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && grp == GRP_STAT) |=> ((stat_q & $past(wdata & ~ev)) == '0));     // R10
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~ack)) == $past(stat_q & ~ack)));       // R10
  AST_LEVEL_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(lvl_ev)) == $past(lvl_ev)));                     // R9
  AST_EDGE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    ((edg_q & ~stat_q) == '0));                                                // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ev)) == '0));                  // R13
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = DATA_W,
  localparam int unsigned PINS     = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BANK_W-1:0] rsp_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq
);
  logic [PINS-1:0]                  pin_sync;
  logic [NUM_BANKS-1:0]             bank_wr;
  logic [NUM_BANKS-1:0]             bank_pend;
  logic [NUM_BANKS-1:0][BANK_W-1:0] bank_rd;
  logic [GRP_W-1:0]                 grp;

  assign req_ready = 1'b1;

  gpio_sync #(.W(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pad_in),
    .dout (pin_sync)
  );

  gpio_regif #(.NB(NUM_BANKS), .W(BANK_W)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .bank_rd  (bank_rd),
    .bank_wr  (bank_wr),
    .grp      (grp),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr[b]),
      .grp     (grp),
      .wdata   (req_wdata),
      .pin_sync(pin_sync[b*BANK_W +: BANK_W]),
      .rd_data (bank_rd[b]),
      .pad_out (pad_out[b*BANK_W +: BANK_W]),
      .pad_oe  (pad_oe[b*BANK_W +: BANK_W]),
      .pend_any(bank_pend[b])
    );
  end

  assign irq = |bank_pend;

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));                                                        // R1
  AST_IRQ_QUIET_AT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);                                                    // R3
endmodule

// File: tb/tb_gpio_banked_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_banked_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [95:0] pad_in = '0;
  logic [95:0] pad_out;
  logic [95:0] pad_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  gpio_banked_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata; v = rsp_valid;
    req_valid = 1'b0;
  endtask

  task automatic read_expect(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic v;
    bus_read(a, d, v);
    check(req, {31'b0, v}, 32'h1);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R3 oe", pad_oe[31:0] | pad_oe[63:32] | pad_oe[95:64], 32'h0);
    check("R3 out", pad_out[31:0] | pad_out[63:32] | pad_out[95:64], 32'h0);
    check("R3 irq", {31'b0, irq}, 32'h0);
    check("R2 ready", {31'b0, req_ready}, 32'h1);
  endtask

  task automatic t_dir_data;
    pad_in[3:0] = 4'h3;
    bus_write(8'h00, 32'h0000_00F0);
    bus_write(8'h20, 32'h0000_00A5);
    check("R3 oe", pad_oe[31:0], 32'h0000_00F0);
    check("R3 out", pad_out[31:0], 32'h0000_00A5);
    check("R1 bank1 oe", pad_oe[63:32], 32'h0);
    read_expect("R4 mixed", 8'h20, 32'h0000_00A3);
    pad_in[1] = 1'b0;
    read_expect("R4 sync latency", 8'h20, 32'h0000_00A3);
    read_expect("R4 sync settled", 8'h20, 32'h0000_00A1);
  endtask

  task automatic t_set_clr;
    bus_write(8'h28, 32'h0F0F_0000);
    bus_write(8'h38, 32'h0000_00F0);
    check("R5 set", pad_out[95:64], 32'h0F0F_00F0);
    bus_write(8'h48, 32'h0F00_0000);
    check("R6 clear", pad_out[95:64], 32'h000F_00F0);
    read_expect("R6 latch read", 8'h38, 32'h000F_00F0);
    check("R5 other bank", pad_out[31:0], 32'h0000_00A5);
  endtask

  task automatic t_polarity;
    bus_write(8'h10, 32'h0000_0004);
    read_expect("R7 invert read", 8'h20, 32'h0000_00A5);
    pad_in[2] = 1'b1;
    wait_clks(3);
    bus_write(8'h50, 32'h0000_0004);
    wait_clks(3);
    read_expect("R7 no rise yet", 8'h90, 32'h0);
    pad_in[2] = 1'b0;
    wait_clks(3);
    read_expect("R7 inverted rise", 8'h90, 32'h0000_0004);
    bus_write(8'h90, 32'h0000_0004);
    bus_write(8'h50, 32'h0);
    bus_write(8'h10, 32'h0);
    read_expect("R10 ack", 8'h90, 32'h0);
  endtask

  task automatic t_edges;
    bus_write(8'h54, 32'h0000_0020);
    pad_in[37] = 1'b1;
    wait_clks(3);
    check("R12 irq bank1", {31'b0, irq}, 32'h1);
    read_expect("R8 rise", 8'h94, 32'h0000_0020);
    read_expect("R11 edge flag", 8'hA4, 32'h0000_0020);
    bus_write(8'hA4, 32'h0);
    read_expect("R11 flag write ignored", 8'hA4, 32'h0000_0020);
    bus_write(8'h94, 32'h0000_0020);
    read_expect("R10 ack", 8'h94, 32'h0);
    read_expect("R11 flag cleared", 8'hA4, 32'h0);
    check("R12 irq low", {31'b0, irq}, 32'h0);
    pad_in[37] = 1'b0;
    wait_clks(3);
    read_expect("R13 fall disabled", 8'h94, 32'h0);
    bus_write(8'h64, 32'h0000_0020);
    pad_in[37] = 1'b1;
    wait_clks(3);
    bus_write(8'h94, 32'h0000_0020);
    pad_in[37] = 1'b0;
    wait_clks(3);
    read_expect("R8 fall", 8'h94, 32'h0000_0020);
    bus_write(8'h94, 32'h0000_0020);
    bus_write(8'h64, 32'h0);
    bus_write(8'h54, 32'h0000_0060);
    pad_in[38:37] = 2'b11;
    wait_clks(3);
    read_expect("R8 two pins", 8'h94, 32'h0000_0060);
    bus_write(8'h94, 32'h0);
    read_expect("R10 zero keeps", 8'h94, 32'h0000_0060);
    bus_write(8'h94, 32'h0000_0020);
    read_expect("R10 one pin", 8'h94, 32'h0000_0040);
    bus_write(8'h94, 32'h0000_0040);
    bus_write(8'h54, 32'h0);
  endtask

  task automatic t_levels;
    bus_write(8'h78, 32'h0000_0001);
    pad_in[64] = 1'b1;
    wait_clks(3);
    read_expect("R9 high", 8'h98, 32'h0000_0001);
    read_expect("R11 level no flag", 8'hA8, 32'h0);
    bus_write(8'h98, 32'h0000_0001);
    read_expect("R9 ack no effect", 8'h98, 32'h0000_0001);
    bus_write(8'h80, 32'h0000_0008);
    wait_clks(2);
    read_expect("R9 low", 8'h90, 32'h0000_0008);
    pad_in[64] = 1'b0;
    wait_clks(3);
    bus_write(8'h98, 32'h0000_0001);
    read_expect("R9 level gone", 8'h98, 32'h0);
    check("R12 irq other bank", {31'b0, irq}, 32'h1);
    pad_in[3] = 1'b1;
    wait_clks(3);
    bus_write(8'h90, 32'h0000_0008);
    read_expect("R10 low cleared", 8'h90, 32'h0);
    check("R12 irq idle", {31'b0, irq}, 32'h0);
    bus_write(8'h78, 32'h0);
    bus_write(8'h80, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [95:0] snap;
    snap = pad_out;
    bus_write(8'h2C, 32'hFFFF_FFFF);
    check("R2 no rsp on write", {31'b0, rsp_valid}, 32'h0);
    bus_write(8'hB0, 32'hFFFF_FFFF);
    bus_write(8'h21, 32'hFFFF_FFFF);
    check("R1 out lo", pad_out[31:0], snap[31:0]);
    check("R1 out mid", pad_out[63:32], snap[63:32]);
    check("R1 out hi", pad_out[95:64], snap[95:64]);
    read_expect("R1 slot3 read", 8'h2C, 32'h0);
    read_expect("R1 group11 read", 8'hB0, 32'h0);
  endtask

  initial begin
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(1);
    t_reset;
    t_dir_data;
    t_set_clr;
    t_polarity;
    t_edges;
    t_levels;
    t_unmapped;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule